// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target has left stuck, typically because the controller was reset in the middle of a transfer while the target kept power. It drives both bus wires through open-drain enables, where an enable of 1 pulls the wire low and 0 releases it. It watches both wires through a two-flop synchroniser and runs a fixed, partly conditional sequence that makes a stuck target abort its write, or finish shifting out its byte and then see a NAK.

The sequence begins with both wires released. A pseudo-stop is SDA pulled low for one bit delay and then released for one bit delay. It is sent only when both wires read high. If the first pseudo-stop cannot be sent, one extra SCL pulse is given and the check is repeated. Then a train of clock pulses runs on time alone, and a last conditional pseudo-stop follows. At the end both wires are released, `done_o` pulses and the final wire levels are reported. A run is started by `start_i`. It also starts when the transfer logic raises `xfer_pending_i` while either wire reads low. Control and status pins are plain levels or pulses and have no handshake.

Top module: `bus_recovery_seq`

## Requirements
- R1: After reset both enables are 0, `busy_o` and `done_o` are 0 and `line_stat_o` is 2'b11.
- R2: `start_i` high in a cycle where the block is idle starts a run. `busy_o` is 1 from the next cycle until the run ends.
- R3: A pseudo-stop is issued only when both synchronised wires read high. It holds `sda_oe_o`=1 for DELAY_CYCLES clocks and then 0 for DELAY_CYCLES clocks, with `scl_oe_o`=0 throughout. The two enables are never 1 together.
- R4: If the first check fails, exactly one extra SCL pulse is given (`scl_oe_o`=1 for DELAY_CYCLES, then 0 for DELAY_CYCLES). Both wires are then checked again, and a pseudo-stop follows only if both read high.
- R5: After the first pseudo-stop phase, exactly NUM_PULSES (default 9) SCL pulses follow, each low for DELAY_CYCLES and released for DELAY_CYCLES. They are timed only, so a wire held low by the target does not stop or stretch them.
- R6: After the pulse train, a final pseudo-stop is issued only if both wires read high.
- R7: The run ends with both enables at 0 and one cycle in which `done_o`=1, in the cycle after `busy_o` falls to 0... precisely, `done_o` is 1 in the first cycle with `busy_o`=0. In that same cycle `line_stat_o` takes the final levels, with bit 1 = SCL high and bit 0 = SDA high, and holds them until the next run ends.
- R8: With the block idle, `xfer_pending_i`=1 starts a run if either synchronised wire reads low, and does nothing if both read high.
- R9: `start_i` while busy is ignored. The run keeps its length and produces a single `done_o` pulse.
- R10: When SCL_PRESENT or SDA_PRESENT is 0, that wire is treated as always high, both in the checks and in `line_stat_o`.
- R11: A run lasts 2·DELAY_CYCLES·(clock pulses + pseudo-stops) + (number of checks) + 1 busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a recovery run |
| xfer_pending_i | input | 1 | Transfer about to be granted; starts a run if the bus looks stuck |
| scl_i | input | 1 | Sampled SCL wire level (asynchronous) |
| sda_i | input | 1 | Sampled SDA wire level (asynchronous) |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| line_stat_o | output | 2 | Final levels: bit 1 SCL high, bit 0 SDA high |

## Verification
The main instance is built with DELAY_CYCLES=4 and the default nine pulses. Each run then lasts about a hundred cycles, which leaves room for many randomised stuck-target scenarios. The target model holds SDA low for a chosen number of SCL pulses, or clamps SCL, and this reaches all three pseudo-stop decisions, the extra clock, and both final outcomes. A second instance with SDA_PRESENT=0 is tied to a permanently low SDA, to show that a missing wire reads as idle.

// File: rtl/bus_rec_pkg.sv
package bus_rec_pkg;
  typedef enum logic [3:0] {
    RS_IDLE, RS_CHECK, RS_PS_LO, RS_PS_HI, RS_XCK_LO, RS_XCK_HI,
    RS_CK_LO, RS_CK_HI, RS_FINISH
  } rec_state_e;

  typedef enum logic [1:0] {
    PH_FIRST, PH_RETRY, PH_LAST
  } rec_phase_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      stab_q <= '1;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
  parameter int DELAY_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R11: each timed phase lasts DELAY_CYCLES, so the count never passes the limit
  p_timer_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq
  import bus_rec_pkg::*;
#(
  parameter int DELAY_CYCLES = 250,
  parameter int NUM_PULSES   = 9,
  parameter bit SCL_PRESENT  = 1'b1,
  parameter bit SDA_PRESENT  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       xfer_pending_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] line_stat_o
);
  localparam int PW = $clog2(NUM_PULSES + 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(NUM_PULSES - 1);

  rec_state_e    state_q, state_d;
  rec_phase_e    phase_q, phase_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic [1:0]    raw_lines, sync_lines;
  logic          scl_s, sda_s, both_high;
  logic          timed, tick;
  logic          done_q;
  logic [1:0]    stat_q;

  // R10: an absent wire reads as high
  generate
    if (SCL_PRESENT) begin : g_scl_pin
      assign raw_lines[1] = scl_i;
    end else begin : g_scl_none
      assign raw_lines[1] = 1'b1;
    end
    if (SDA_PRESENT) begin : g_sda_pin
      assign raw_lines[0] = sda_i;
    end else begin : g_sda_none
      assign raw_lines[0] = 1'b1;
    end
  endgenerate

  line_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_lines), .q_o(sync_lines)
  );

  assign scl_s     = sync_lines[1];
  assign sda_s     = sync_lines[0];
  assign both_high = scl_s && sda_s;

  assign timed = (state_q == RS_PS_LO)  || (state_q == RS_PS_HI) ||
                 (state_q == RS_XCK_LO) || (state_q == RS_XCK_HI) ||
                 (state_q == RS_CK_LO)  || (state_q == RS_CK_HI);

  bit_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(timed), .expire_o(tick)
  );

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    pulse_d = pulse_q;
    unique case (state_q)
      RS_IDLE: begin
        if (start_i || (xfer_pending_i && !both_high)) begin
          state_d = RS_CHECK;
          phase_d = PH_FIRST;
          pulse_d = '0;
        end
      end
      RS_CHECK: begin
        if (both_high)                state_d = RS_PS_LO;
        else if (phase_q == PH_FIRST) state_d = RS_XCK_LO;
        else if (phase_q == PH_RETRY) state_d = RS_CK_LO;
        else                          state_d = RS_FINISH;
      end
      RS_PS_LO:  if (tick) state_d = RS_PS_HI;
      RS_PS_HI: begin
        if (tick) state_d = (phase_q == PH_LAST) ? RS_FINISH : RS_CK_LO;
      end
      RS_XCK_LO: if (tick) state_d = RS_XCK_HI;
      RS_XCK_HI: begin
        if (tick) begin
          phase_d = PH_RETRY;
          state_d = RS_CHECK;
        end
      end
      RS_CK_LO:  if (tick) state_d = RS_CK_HI;
      RS_CK_HI: begin
        if (tick) begin
          if (pulse_q == PULSE_LAST) begin
            phase_d = PH_LAST;
            state_d = RS_CHECK;
          end else begin
            pulse_d = pulse_q + 1'b1;
            state_d = RS_CK_LO;
          end
        end
      end
      RS_FINISH: state_d = RS_IDLE;
      default:   state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      phase_q <= PH_FIRST;
      pulse_q <= '0;
      done_q  <= 1'b0;
      stat_q  <= 2'b11;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      pulse_q <= pulse_d;
      done_q  <= (state_q == RS_FINISH);
      if (state_q == RS_FINISH) stat_q <= sync_lines;
    end
  end

  assign scl_oe_o    = (state_q == RS_XCK_LO) || (state_q == RS_CK_LO);
  assign sda_oe_o    = (state_q == RS_PS_LO);
  assign busy_o      = (state_q != RS_IDLE);
  assign done_o      = done_q;
  assign line_stat_o = stat_q;

  // R3: SDA is pulled only while SCL is released
  p_drive_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> !scl_oe_o);
  // R3: a pseudo-stop begins only after both wires were seen high
  p_ps_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(both_high));
  // R5: the pulse index stays within the train
  p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q <= PULSE_LAST);
  // R7: done is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7: end of busy coincides with done
  p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  // R7: both wires released whenever idle
  p_idle_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));
endmodule

// File: tb/test_bus_recovery_seq.sv
module test_bus_recovery_seq;
  localparam int D = 4;
  localparam int NP = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, xreq, scl_stuck, start2;
  int   hold_k;
  int   edge_cnt;
  logic edge_clr, scl_oe_d;
  logic scl_oe, sda_oe, busy, done;
  logic [1:0] stat;
  logic scl_line, sda_line;
  logic scl_oe2, sda_oe2, busy2, done2;
  logic [1:0] stat2;
  int checks = 0, errors = 0, cyc = 0;

  assign sda_line = !(sda_oe || (edge_cnt < hold_k));
  assign scl_line = !(scl_oe || scl_stuck);

  bus_recovery_seq #(.DELAY_CYCLES(D), .NUM_PULSES(NP)) i_bus_recovery_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .xfer_pending_i(xreq),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .busy_o(busy), .done_o(done), .line_stat_o(stat));

  bus_recovery_seq #(.DELAY_CYCLES(D), .NUM_PULSES(NP), .SDA_PRESENT(1'b0))
    i_bus_recovery_seq_nopin (
    .clk(clk), .rst_n(rst_n), .start_i(start2), .xfer_pending_i(1'b0),
    .scl_i(!scl_oe2), .sda_i(1'b0), .scl_oe_o(scl_oe2), .sda_oe_o(sda_oe2),
    .busy_o(busy2), .done_o(done2), .line_stat_o(stat2));

  // target model: keeps SDA low until it has seen hold_k SCL pulses
  always @(posedge clk) begin
    cyc <= cyc + 1;
    scl_oe_d <= scl_oe;
    if (edge_clr) edge_cnt <= 0;
    else if (scl_oe && !scl_oe_d) edge_cnt <= edge_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void expect_run(input int k, input bit stuck, input bit sdap,
                                     output int e, output int ps, output int bcyc,
                                     output int st);
    bit scl_h;
    int nchk;
    scl_h = !stuck;
    e = 0; ps = 0; nchk = 1;
    if (scl_h && (!sdap || k <= 0)) ps++;
    else begin
      e = 1; nchk++;
      if (scl_h && (!sdap || k <= 1)) ps++;
    end
    e += NP; nchk++;
    if (scl_h && (!sdap || k <= e)) ps++;
    bcyc = 2 * D * (e + ps) + nchk + 1;
    st = {30'd0, scl_h, (!sdap || k <= e)};
  endfunction

  task automatic run_case(input int k, input bit stuck, input bit auto_trig,
                          input bit poke);
    int e, ps, bc, st;
    int n_scl = 0, n_sda = 0, nbusy = 0, ndone = 0, steps = 0;
    logic ps_scl, ps_sda;
    expect_run(k, stuck, 1'b1, e, ps, bc, st);
    @(negedge clk);
    hold_k = k; scl_stuck = stuck; edge_clr = 1'b1;
    @(negedge clk);
    edge_clr = 1'b0;
    repeat (4) @(negedge clk);
    if (auto_trig) xreq = 1'b1; else start = 1'b1;
    ps_scl = scl_oe; ps_sda = sda_oe;
    @(negedge clk);
    xreq = 1'b0; start = 1'b0;
    check(busy == 1'b1, auto_trig ? "R8" : "R2", busy, 1);
    while (steps < 2000) begin
      if (busy) nbusy++;
      if (done) begin ndone++; break; end
      if (scl_oe && !ps_scl) n_scl++;
      if (sda_oe && !ps_sda) n_sda++;
      if (scl_oe && sda_oe) check(0, "R3", 1, 0);
      ps_scl = scl_oe; ps_sda = sda_oe;
      if (poke && steps == 30) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      steps++;
    end
    check(n_scl == e, (e == NP + 1) ? "R4" : "R5", n_scl, e);
    check(n_sda == ps, "R3/R6 pseudo-stops", n_sda, ps);
    check(nbusy == bc, poke ? "R9" : "R11", nbusy, bc);
    check(ndone == 1 && !busy, "R7 done", ndone, 1);
    check(stat == st[1:0], "R7 status", stat, st);
    repeat (3) begin
      @(negedge clk);
      check(!done && !busy && !scl_oe && !sda_oe, "R7 idle", {done, busy}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; start = 1'b0; xreq = 1'b0; start2 = 1'b0;
    scl_stuck = 1'b0; hold_k = 0; edge_clr = 1'b1; scl_oe_d = 1'b0; edge_cnt = 0;
    repeat (3) @(negedge clk);
    check(!scl_oe && !sda_oe && !busy && !done && stat == 2'b11, "R1",
          {scl_oe, sda_oe, busy, done, stat}, 6'b000011);
    rst_n = 1'b1;
    @(negedge clk);
    edge_clr = 1'b0;

    // R8: pending transfer on a healthy bus starts nothing
    xreq = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check(!busy, "R8 no run", busy, 0);
    end
    xreq = 1'b0;

    run_case(0, 1'b0, 1'b0, 1'b0);   // clean bus: both pseudo-stops
    run_case(1, 1'b0, 1'b0, 1'b0);   // R4: extra clock frees SDA
    run_case(2, 1'b0, 1'b0, 1'b0);   // R4: retry also fails
    run_case(11, 1'b0, 1'b0, 1'b0);  // R6: SDA still low at the end
    run_case(10, 1'b0, 1'b0, 1'b0);  // R6: freed on the last pulse
    run_case(0, 1'b1, 1'b0, 1'b0);   // R5: SCL clamped, pulses timed only
    run_case(3, 1'b0, 1'b1, 1'b0);   // R8: auto trigger
    run_case(0, 1'b1, 1'b1, 1'b0);   // R8: auto trigger on SCL low
    run_case(5, 1'b0, 1'b0, 1'b1);   // R9: start while busy
    for (int i = 0; i < 16; i++)
      run_case(int'($urandom % 13), ($urandom % 6) == 0, ($urandom % 3) == 0,
               ($urandom % 4) == 0);

    // R10: absent SDA reads high although the wire is tied low
    begin
      int e, ps, bc, st, n_sda = 0, steps = 0;
      logic p_sda = 1'b0;
      expect_run(100, 1'b0, 1'b0, e, ps, bc, st);
      @(negedge clk); start2 = 1'b1;
      @(negedge clk); start2 = 1'b0;
      while (!done2 && steps < 2000) begin
        if (sda_oe2 && !p_sda) n_sda++;
        p_sda = sda_oe2;
        @(negedge clk);
        steps++;
      end
      check(n_sda == ps, "R10 pseudo-stops", n_sda, ps);
      check(stat2 == st[1:0], "R10 status", stat2, st);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule